// File: doc/BRIEF.md
# CAN Interrupt Source Aggregator

This block sits beside a CAN protocol engine. It turns that engine's one-cycle event strobes into sticky status flags, masks them with enable flags, and drives four interrupt request lines. The six sources are transmit done, receive done, error-state change, protocol error, arbitration lost and wakeup. Three of them (error-state change, protocol error and arbitration lost) share a single error request line. Software reads the status vector to find out which of the three fired.

The wakeup source is produced inside the block. While the sleep input is high, the receive pin is synchronized and watched for a recessive-to-dominant (high-to-low) transition. Transmit and receive strobes are counted only when they arrive together with the originating message buffer's own interrupt-enable flag.

A small write port updates the enable and status vectors. The select code picks one of four actions, and each written 1 either sets or clears the matching bit. Both vectors are visible at the outputs at all times.

Top module: `can_irq_merge`

## Requirements
- R1: While reset is held and right after it, the status vector, the enable vector and all four request outputs are 0.
- R2: A transmit strobe sets status bit 0 at the clock edge that samples it, but only if `tx_buf_ie_i` is 1 in the same cycle. With the flag at 0 the strobe has no effect.
- R3: A receive strobe sets status bit 1 at the clock edge that samples it, but only if `rx_buf_ie_i` is 1 in the same cycle. With the flag at 0 the strobe has no effect.
- R4: The error-state, protocol-error and arbitration-lost strobes set status bits 2, 3 and 4 respectively. Any of these three bits, when set and enabled, raises `irq_err_o`.
- R5: With `sleep_mode_i` high, a high-to-low transition on `rx_pin_i` sets status bit 5 on the third rising edge after the pin falls (two synchronizer stages, then the status register). With `sleep_mode_i` low, the same transition does nothing.
- R6: A status bit is set by its event whatever the state of its enable bit. The enable bit only gates the request output, and status bits stay set until software clears them.
- R7: Each request output is registered and follows its enabled, set status bits one clock edge after the status or enable change. The mapping is: `irq_tx_o` from bit 0, `irq_rx_o` from bit 1, `irq_err_o` from bits 2 to 4, and `irq_wup_o` from bit 5.
- R8: A write with select 3 clears each status bit where the write data is 1. If an event for a bit arrives in the same cycle as its clear, the bit stays set.
- R9: A write with select 0 sets enable bits and a write with select 1 clears enable bits, in each case where the write data is 1. Other enable bits are unchanged.
- R10: A write with select 2 sets status bits where the write data is 1. The request outputs then follow as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done_i | input | 1 | Transmit-complete strobe |
| tx_buf_ie_i | input | 1 | Interrupt-enable flag of the transmitting buffer |
| rx_done_i | input | 1 | Receive-complete strobe |
| rx_buf_ie_i | input | 1 | Interrupt-enable flag of the receiving buffer |
| err_state_i | input | 1 | Error-state change strobe (warning level, passive, bus-off) |
| proto_err_i | input | 1 | Protocol error strobe (stuff, form, ack, bit, CRC) |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| sleep_mode_i | input | 1 | Sleep mode level; arms the wakeup detector |
| rx_pin_i | input | 1 | Asynchronous receive pin level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 enable set, 1 enable clear, 2 status set, 3 status clear |
| reg_wdata_i | input | 6 | Per-source write mask |
| status_o | output | 6 | Sticky status vector |
| enable_o | output | 6 | Enable vector |
| irq_tx_o | output | 1 | Transmit request |
| irq_rx_o | output | 1 | Receive request |
| irq_err_o | output | 1 | Shared error request |
| irq_wup_o | output | 1 | Wakeup request |

## Verification
Every strobe and every register write takes effect on the status or enable vector at the first rising edge that samples it. Each request line follows one edge after that. A wakeup needs three edges after the pin falls before status bit 5 is set, and a fourth before `irq_wup_o` rises. The bench drives all inputs on the falling edge and reads all outputs on the falling edge. It counts the exact number of falling edges for each of these latencies. In the wakeup case it also checks that status bit 5 is still 0 on the edges just before it is due.

// File: rtl/can_irq_merge.sv
module can_irq_merge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_done_i,
  input  logic       tx_buf_ie_i,
  input  logic       rx_done_i,
  input  logic       rx_buf_ie_i,
  input  logic       err_state_i,
  input  logic       proto_err_i,
  input  logic       arb_lost_i,
  input  logic       sleep_mode_i,
  input  logic       rx_pin_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_sel_i,
  input  logic [5:0] reg_wdata_i,
  output logic [5:0] status_o,
  output logic [5:0] enable_o,
  output logic       irq_tx_o,
  output logic       irq_rx_o,
  output logic       irq_err_o,
  output logic       irq_wup_o
);
  localparam int NSRC = 6;

  logic [SYNC_STAGES-1:0] rx_sync;
  logic                   rx_prev;
  logic                   rx_s;
  logic                   wake_edge;
  logic [NSRC-1:0]        evt;
  logic [NSRC-1:0]        stat_q, en_q;
  logic [NSRC-1:0]        stat_set, stat_clr, en_set, en_clr;
  logic [NSRC-1:0]        live;

  assign rx_s      = rx_sync[SYNC_STAGES-1];
  assign wake_edge = sleep_mode_i & rx_prev & ~rx_s;

  assign evt = {wake_edge, arb_lost_i, proto_err_i, err_state_i,
                rx_done_i & rx_buf_ie_i, tx_done_i & tx_buf_ie_i};

  assign en_set   = (reg_wr_i && reg_sel_i == 2'd0) ? reg_wdata_i : '0;
  assign en_clr   = (reg_wr_i && reg_sel_i == 2'd1) ? reg_wdata_i : '0;
  assign stat_set = (reg_wr_i && reg_sel_i == 2'd2) ? reg_wdata_i : '0;
  assign stat_clr = (reg_wr_i && reg_sel_i == 2'd3) ? reg_wdata_i : '0;

  assign live = stat_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync <= '1;
      rx_prev <= 1'b1;
    end else begin
      rx_sync <= {rx_sync[SYNC_STAGES-2:0], rx_pin_i};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set | evt;
      en_q   <= (en_q | en_set) & ~en_clr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_tx_o  <= 1'b0;
      irq_rx_o  <= 1'b0;
      irq_err_o <= 1'b0;
      irq_wup_o <= 1'b0;
    end else begin
      irq_tx_o  <= live[0];
      irq_rx_o  <= live[1];
      irq_err_o <= |live[4:2];
      irq_wup_o <= live[5];
    end
  end

  assign status_o = stat_q;
  assign enable_o = en_q;

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_i && tx_buf_ie_i |=> status_o[0]); // R2
  AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i && rx_buf_ie_i |=> status_o[1]); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_sel_i == 2'd3) |=> (status_o & $past(status_o)) == $past(status_o)); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_i && reg_wr_i && reg_sel_i == 2'd3 |=> status_o[3]); // R8
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[5]) |-> $past(sleep_mode_i) ||
      $past(reg_wr_i && reg_sel_i == 2'd2 && reg_wdata_i[5])); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4:2] & enable_o[4:2]) == 3'b000 |=> !irq_err_o); // R7
endmodule

// File: tb/can_irq_merge_tb_top.sv
module can_irq_merge_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic tx_done_i = 0, tx_buf_ie_i = 0, rx_done_i = 0, rx_buf_ie_i = 0;
  logic err_state_i = 0, proto_err_i = 0, arb_lost_i = 0;
  logic sleep_mode_i = 0, rx_pin_i = 1, reg_wr_i = 0;
  logic [1:0] reg_sel_i = 0;
  logic [5:0] reg_wdata_i = 0;
  logic [5:0] status_o, enable_o;
  logic irq_tx_o, irq_rx_o, irq_err_o, irq_wup_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_irq_merge dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] irqs();
    return {irq_wup_o, irq_err_o, irq_rx_o, irq_tx_o};
  endfunction

  task automatic wr(logic [1:0] sel, logic [5:0] d);
    reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = d;
    step();
    reg_wr_i = 0; reg_wdata_i = 0;
  endtask

  task automatic clear_all();
    wr(2'd3, 6'h3f);
    step();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 0);
    chk("R1 enable", enable_o, 0);
    chk("R1 irqs", irqs(), 0);
  endtask

  task automatic t_tx_rx();
    wr(2'd0, 6'h3f);
    chk("R9 enable set", enable_o, 6'h3f);
    tx_done_i = 1; tx_buf_ie_i = 0; step(); tx_done_i = 0;
    chk("R2 gated tx", status_o, 0);
    tx_done_i = 1; tx_buf_ie_i = 1; step(); tx_done_i = 0; tx_buf_ie_i = 0;
    chk("R2 tx sets bit0", status_o, 6'h01);
    step();
    chk("R7 irq_tx", irqs(), 4'b0001);
    clear_all();
    chk("R8 cleared", status_o, 0);
    chk("R7 irq_tx drop", irqs(), 0);
    rx_done_i = 1; rx_buf_ie_i = 0; step(); rx_done_i = 0;
    chk("R3 gated rx", status_o, 0);
    rx_done_i = 1; rx_buf_ie_i = 1; step(); rx_done_i = 0; rx_buf_ie_i = 0;
    chk("R3 rx sets bit1", status_o, 6'h02);
    step();
    chk("R7 irq_rx", irqs(), 4'b0010);
    clear_all();
  endtask

  task automatic t_err();
    err_state_i = 1; step(); err_state_i = 0;
    chk("R4 err_state bit2", status_o, 6'h04);
    step(); chk("R4 irq_err a", irqs(), 4'b0100);
    clear_all();
    proto_err_i = 1; step(); proto_err_i = 0;
    chk("R4 proto bit3", status_o, 6'h08);
    step(); chk("R4 irq_err b", irqs(), 4'b0100);
    clear_all();
    arb_lost_i = 1; step(); arb_lost_i = 0;
    chk("R4 arb bit4", status_o, 6'h10);
    step(); chk("R4 irq_err c", irqs(), 4'b0100);
    clear_all();
  endtask

  task automatic t_mask();
    wr(2'd1, 6'h3f);
    chk("R9 enable clear", enable_o, 0);
    tx_done_i = 1; tx_buf_ie_i = 1; step(); tx_done_i = 0; tx_buf_ie_i = 0;
    chk("R6 status set while masked", status_o, 6'h01);
    step(2);
    chk("R6 masked no irq", irqs(), 0);
    chk("R6 sticky", status_o, 6'h01);
    wr(2'd0, 6'h01);
    chk("R9 partial enable", enable_o, 6'h01);
    step();
    chk("R7 irq after enable", irqs(), 4'b0001);
    clear_all();
  endtask

  task automatic t_wakeup();
    wr(2'd0, 6'h3f);
    sleep_mode_i = 0; rx_pin_i = 0; step(6);
    chk("R5 awake no wakeup", status_o, 0);
    rx_pin_i = 1; step(4);
    sleep_mode_i = 1; step();
    rx_pin_i = 0;
    step(2);
    chk("R5 not yet", status_o[5], 0);
    step();
    chk("R5 wakeup bit5", status_o, 6'h20);
    step();
    chk("R7 irq_wup", irqs(), 4'b1000);
    rx_pin_i = 1; sleep_mode_i = 0;
    clear_all();
    step(4);
    chk("R5 rising edge ignored", status_o, 0);
  endtask

  task automatic t_race();
    err_state_i = 1; step(); err_state_i = 0;
    proto_err_i = 1; reg_wr_i = 1; reg_sel_i = 2'd3; reg_wdata_i = 6'h0c;
    step();
    proto_err_i = 0; reg_wr_i = 0; reg_wdata_i = 0;
    chk("R8 event wins clear", status_o, 6'h08);
    clear_all();
    wr(2'd2, 6'h30);
    chk("R10 sw set", status_o, 6'h30);
    step();
    chk("R10 irqs follow", irqs(), 4'b1100);
    clear_all();
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_tx_rx();
    t_err();
    t_mask();
    t_wakeup();
    t_race();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule